// File: doc/BRIEF.md
# Host Bus FIFO Direct-Write Decoder

This block is the slave-side write path of an asynchronous 32-bit parallel host bus. The host drives an active-low chip select, an active-low write strobe, an address, the write data, a FIFO-select line and an endian-select line. The block brings both strobes into the local clock domain and follows each write cycle from its start to its end. At the end of the cycle it captures the address, data and select lines. It then issues exactly one action: either a push into a transmit data FIFO or a write on a register port.

FIFO-select is sampled like an address bit. While it is high, every write becomes a FIFO push, whatever the upper address bits hold. A host that must increment its address on each access can therefore stream words into the FIFO. The endian-select line reverses the byte order of the word. A gap between cycles that is shorter than a set number of local clocks sets a sticky error flag. A push that meets a full FIFO is dropped and sets a sticky overflow flag.

Top module: `host_fifo_write_decoder`

## Requirements
- R1: A write cycle begins only while both `cs_ni` and `wr_ni` are low at once. A cycle in which the two strobes are never low together produces neither a push nor a register write.
- R2: A cycle ends when either strobe rises, or both rise together. Either release order ends the cycle, and each completed cycle yields exactly one action.
- R3: When the latched FIFO-select is 1, the word is pushed to the FIFO whatever the address. `addr_i[7:1]` (address bits 9..3) have no effect on the push. `addr_i[0]` (address bit 2) is forwarded on `fifo_word_sel_o`.
- R4: When the latched FIFO-select is 0, the block pulses `reg_we_o` with `reg_addr_o` equal to `addr_i` (address bits 9..2) and `reg_data_o` equal to the word.
- R5: FIFO-select, endian-select, address and data are latched together at the end of the cycle. The select value held at the cycle's end decides the route.
- R6: When the latched endian-select is 1, the word is byte-reversed: output byte k equals input byte 3-k. When it is 0, the word passes unchanged.
- R7: If the synchronised idle gap before a cycle is shorter than `MIN_GAP` clocks, `gap_err_o` is set and stays set until reset. Gaps of at least `MIN_GAP` clocks leave it at 0.
- R8: If `fifo_full_i` is high when a push is due, no push is issued and `ovf_err_o` is set and stays set until reset. Later pushes with the FIFO not full proceed.
- R9: During and right after reset, `fifo_push_o`, `reg_we_o`, `gap_err_o` and `ovf_err_o` are 0.
- R10: `fifo_push_o` and `reg_we_o` are single-clock pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low, asynchronous |
| wr_ni | input | 1 | Host write strobe, active low, asynchronous |
| fifo_sel_i | input | 1 | Route select: 1 sends the write to the FIFO |
| end_sel_i | input | 1 | Byte-reverse select |
| addr_i | input | ADDR_W (8) | Host address bits 9..2, with bit 0 carrying address bit 2 |
| data_i | input | DATA_W (32) | Host write data |
| fifo_full_i | input | 1 | Transmit FIFO full indication |
| fifo_push_o | output | 1 | One-clock push strobe |
| fifo_data_o | output | DATA_W (32) | Word to push |
| fifo_word_sel_o | output | 1 | Address bit 2 of the pushed word |
| reg_we_o | output | 1 | One-clock register write strobe |
| reg_addr_o | output | ADDR_W (8) | Register address (bits 9..2) |
| reg_data_o | output | DATA_W (32) | Register write data |
| gap_err_o | output | 1 | Sticky idle-gap violation flag |
| ovf_err_o | output | 1 | Sticky dropped-push flag |

## Verification
Two events fall in the same local clock: the end-of-cycle routing decision that would issue a push, and the detection of a full FIFO that must drop the push and raise the overflow flag. The bench holds `fifo_full_i` high across the end of a FIFO-routed cycle. It then judges that no push strobe appeared and that the overflow flag went high in that same step. A later FIFO write with the FIFO not full must push normally while the flag stays set.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  localparam int unsigned MIN_SYNC_STAGES = 2;

  typedef struct packed {
    logic fifo_sel;
    logic end_sel;
  } hbw_sel_t;
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= {STAGES{RST_VAL[b]}};
      else         sh <= {sh[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/hbw_cycle_track.sv
module hbw_cycle_track #(
  parameter int unsigned MIN_GAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic wr_s_i,
  output logic end_o,
  output logic gap_err_o
);
  localparam int unsigned GW = $clog2(MIN_GAP + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);

  logic          act, act_q, start;
  logic [GW-1:0] idle_cnt;
  logic          gap_q;

  assign act   = ~cs_s_i & ~wr_s_i;
  assign start = act & ~act_q;
  assign end_o = ~act & act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  // saturating idle counter; reset value lets the first cycle pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_cnt <= GAP_MAX;
    else if (act)                idle_cnt <= '0;
    else if (idle_cnt != GAP_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           gap_q <= 1'b0;
    else if (start && (idle_cnt < GAP_MAX)) gap_q <= 1'b1;
  end
  assign gap_err_o = gap_q;

  // R2
  end_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
  // R7
  gap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_err_o |=> gap_err_o);
endmodule

// File: rtl/hbw_route.sv
module hbw_route
  import hbw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  hbw_sel_t          sel_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [DATA_W-1:0] fdata_o,
  output logic              fword_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [DATA_W-1:0] swapped, word;

  for (genvar k = 0; k < NB; k++) begin : g_swap
    assign swapped[8*k +: 8] = data_i[8*(NB-1-k) +: 8];
  end
  assign word = sel_i.end_sel ? swapped : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o  <= 1'b0;
      we_o    <= 1'b0;
      ovf_o   <= 1'b0;
      fdata_o <= '0;
      fword_o <= 1'b0;
      raddr_o <= '0;
      rdata_o <= '0;
    end else begin
      push_o <= 1'b0;
      we_o   <= 1'b0;
      if (end_i) begin
        if (sel_i.fifo_sel) begin
          if (fifo_full_i) begin
            ovf_o <= 1'b1;
          end else begin
            push_o  <= 1'b1;
            fdata_o <= word;
            fword_o <= addr_i[0];
          end
        end else begin
          we_o    <= 1'b1;
          raddr_o <= addr_i;
          rdata_o <= word;
        end
      end
    end
  end
endmodule

// File: rtl/host_fifo_write_decoder.sv
module host_fifo_write_decoder
  import hbw_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES,
  parameter int unsigned MIN_GAP     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              fifo_sel_i,
  input  logic              end_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fifo_full_i,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              fifo_word_sel_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              gap_err_o,
  output logic              ovf_err_o
);
  logic [1:0] strb_s;
  logic       cyc_end;
  hbw_sel_t   sel;

  hbw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, wr_ni}),
    .q_o    (strb_s)
  );

  hbw_cycle_track #(.MIN_GAP(MIN_GAP)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (strb_s[1]),
    .wr_s_i    (strb_s[0]),
    .end_o     (cyc_end),
    .gap_err_o (gap_err_o)
  );

  assign sel.fifo_sel = fifo_sel_i;
  assign sel.end_sel  = end_sel_i;

  hbw_route #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .end_i       (cyc_end),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .sel_i       (sel),
    .fifo_full_i (fifo_full_i),
    .push_o      (fifo_push_o),
    .fdata_o     (fifo_data_o),
    .fword_o     (fifo_word_sel_o),
    .we_o        (reg_we_o),
    .raddr_o     (reg_addr_o),
    .rdata_o     (reg_data_o),
    .ovf_o       (ovf_err_o)
  );

  // R10
  push_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |=> !fifo_push_o);
  // R10
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_push_o && reg_we_o));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);
  // R8
  ovf_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_err_o) |-> !fifo_push_o);
endmodule

// File: tb/host_fifo_write_decoder_bench.sv
module host_fifo_write_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, fsel = 1'b0, esel = 1'b0, full = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] data = '0;
  logic        push, fword, we, gerr, oerr;
  logic [31:0] fdata, rdata;
  logic [7:0]  raddr;

  int checks = 0, failures = 0;
  int push_cnt = 0, reg_cnt = 0, wide_cnt = 0;
  logic        prev_push = 1'b0, prev_we = 1'b0;
  logic [31:0] last_fdata = '0, last_rdata = '0;
  logic [7:0]  last_raddr = '0;
  logic        last_fword = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  host_fifo_write_decoder u_host_fifo_write_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
    .fifo_sel_i(fsel), .end_sel_i(esel), .addr_i(addr), .data_i(data),
    .fifo_full_i(full), .fifo_push_o(push), .fifo_data_o(fdata),
    .fifo_word_sel_o(fword), .reg_we_o(we), .reg_addr_o(raddr),
    .reg_data_o(rdata), .gap_err_o(gerr), .ovf_err_o(oerr)
  );

  always @(negedge clk) begin
    if (push) begin push_cnt++; last_fdata = fdata; last_fword = fword; end
    if (we)   begin reg_cnt++;  last_raddr = raddr; last_rdata = rdata; end
    if ((push && prev_push) || (we && prev_we) || (push && we)) wide_cnt++;
    prev_push = push;
    prev_we   = we;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: wr released first, 1: cs released first, 2: both together
  task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                          input logic fs0, input logic fs, input logic es, input int mode);
    @(negedge clk); addr = a; data = d; fsel = fs0; esel = es; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    fsel = fs;
    @(negedge clk);
    case (mode)
      0: begin wr_n = 1'b1; @(negedge clk); cs_n = 1'b1; end
      1: begin cs_n = 1'b1; @(negedge clk); wr_n = 1'b1; end
      default: begin cs_n = 1'b1; wr_n = 1'b1; end
    endcase
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 push in reset", push, 0);
    chk("R9 flags in reset", {gerr, oerr, we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 outputs after reset", {push, we, gerr, oerr}, 0);
  endtask

  task automatic t_reg;
    int r0 = reg_cnt, p0 = push_cnt;
    do_write(8'hA5, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 one reg write", reg_cnt - r0, 1);
    chk("R4 reg addr", last_raddr, 8'hA5);
    chk("R4 reg data", last_rdata, 32'hDEADBEEF);
    chk("R4 no push", push_cnt - p0, 0);
  endtask

  task automatic t_fifo;
    int p0 = push_cnt, r0 = reg_cnt;
    do_write(8'hFE, 32'h01020304, 1'b1, 1'b1, 1'b0, 0);
    chk("R3 data upper addr set", last_fdata, 32'h01020304);
    chk("R3 word sel 0", last_fword, 1'b0);
    do_write(8'h03, 32'hCAFEF00D, 1'b1, 1'b1, 1'b0, 0);
    chk("R3 data other addr", last_fdata, 32'hCAFEF00D);
    chk("R3 word sel 1", last_fword, 1'b1);
    chk("R3 two pushes", push_cnt - p0, 2);
    chk("R3 no reg write", reg_cnt - r0, 0);
  endtask

  task automatic t_swap;
    do_write(8'h00, 32'h11223344, 1'b1, 1'b1, 1'b1, 0);
    chk("R6 fifo swapped", last_fdata, 32'h44332211);
    do_write(8'h10, 32'hA1B2C3D4, 1'b0, 1'b0, 1'b1, 0);
    chk("R6 reg swapped", last_rdata, 32'hD4C3B2A1);
  endtask

  task automatic t_order;
    int p0 = push_cnt;
    do_write(8'h00, 32'h0000AAAA, 1'b1, 1'b1, 1'b0, 1);
    chk("R2 cs first", last_fdata, 32'h0000AAAA);
    do_write(8'h00, 32'h0000BBBB, 1'b1, 1'b1, 1'b0, 2);
    chk("R2 both together", last_fdata, 32'h0000BBBB);
    chk("R2 one push per cycle", push_cnt - p0, 2);
  endtask

  task automatic t_no_overlap;
    int p0 = push_cnt, r0 = reg_cnt;
    @(negedge clk); fsel = 1'b1; cs_n = 1'b0;
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 no action without overlap", (push_cnt - p0) + (reg_cnt - r0), 0);
  endtask

  task automatic t_sel_latch;
    int p0 = push_cnt, r0 = reg_cnt;
    do_write(8'h40, 32'h5A5A0001, 1'b0, 1'b1, 1'b0, 0);
    chk("R5 late select pushes", push_cnt - p0, 1);
    chk("R5 late select no reg", reg_cnt - r0, 0);
    chk("R7 no gap error on long gaps", gerr, 0);
  endtask

  task automatic t_gap;
    int p0 = push_cnt;
    @(negedge clk); fsel = 1'b1; esel = 1'b0; data = 32'h77770001; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 short gap flagged", gerr, 1);
    chk("R2 both short-gap cycles pushed", push_cnt - p0, 2);
    do_write(8'h00, 32'h1, 1'b1, 1'b1, 1'b0, 0);
    chk("R7 flag sticky", gerr, 1);
  endtask

  task automatic t_ovf;
    int p0 = push_cnt;
    full = 1'b1;
    do_write(8'h00, 32'hBAD0BAD0, 1'b1, 1'b1, 1'b0, 0);
    chk("R8 push dropped", push_cnt - p0, 0);
    chk("R8 overflow set", oerr, 1);
    full = 1'b0;
    do_write(8'h00, 32'h600D600D, 1'b1, 1'b1, 1'b0, 0);
    chk("R8 push resumes", last_fdata, 32'h600D600D);
    chk("R8 overflow sticky", oerr, 1);
  endtask

  initial begin
    t_reset();
    t_reg();
    t_fifo();
    t_swap();
    t_order();
    t_no_overlap();
    t_sel_latch();
    t_gap();
    t_ovf();
    chk("R10 strobes single clock and exclusive", wide_cnt, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule